// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is a small bus master that moves a 32-bit processor core from either a reset or an accepted interrupt into normal program execution. It does the memory traffic that must happen before the first instruction is fetched. On a reset it reads two words from a vector table: the start address and the initial stack pointer. On an interrupt it first saves the status word and the program counter on the current stack. It then reads the handler address from the table slot selected by the vector number.

The core drives its current program counter, status word and stack pointer into the block. The block returns new program counter and stack pointer values with a one-cycle load strobe. Every bus access uses a request/ready handshake. The vector table sits at a configurable base with one 4-byte word per entry. Reset uses entries 0 and 1. An interrupt uses the entry equal to its vector number. The stack grows downward.

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst_n` is sampled low, the block is idle: `busy`, `mem_req`, `done`, `pc_load` and `sp_load` are all 0.
- R2: While `rst_req` is high, the block is busy and makes no bus access. After `rst_req` falls, it makes exactly two reads: first at table base + 0, then at table base + 4. It makes no write.
- R3: A reset sequence ends with one cycle in which `done`, `pc_load` and `sp_load` are all 1. In that cycle, `pc_value` holds the word read from offset 0 and `sp_value` holds the word read from offset 4.
- R4: When the block is idle, `irq_req` is high and `rst_req` is low, the request is accepted and `busy` rises. At that point `cur_pc`, `cur_sr`, `cur_sp` and `irq_vec` are captured. Later changes on those inputs have no effect on the sequence.
- R5: An accepted interrupt writes the captured status word to address SP-4 first. It then writes the captured program counter to address SP-8. SP here is the captured stack pointer. The status word is always written before the program counter.
- R6: After both writes, the block reads table base + 4 × vector. It then ends with one cycle of `done`, `pc_load` and `sp_load`, with `pc_value` equal to the word read and `sp_value` equal to SP-8.
- R7: A bus access keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready` is sampled high. The sequence moves on only when `mem_ready` is high.
- R8: `rst_req` has priority. It aborts an interrupt sequence in progress, so no further writes happen, and the reset sequence of R2 and R3 then runs. If `rst_req` and `irq_req` arrive in the same cycle, only the reset sequence runs.
- R9: `irq_req` is ignored while `busy` is high. A request that is held only during a busy period starts no sequence and does not change the results.
- R10: `done`, `pc_load` and `sp_load` are single-cycle pulses. `busy` is low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_req | input | 1 | Core reset request, level; the reset sequence starts when it falls |
| irq_req | input | 1 | Interrupt request from the arbiter |
| irq_vec | input | VEC_W | Vector number for the interrupt request |
| cur_pc | input | XLEN | Program counter of the core |
| cur_sr | input | XLEN | Status word of the core |
| cur_sp | input | XLEN | Stack pointer of the core |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Access completes in this cycle |
| pc_load | output | 1 | Load pc_value into the core program counter |
| pc_value | output | XLEN | New program counter |
| sp_load | output | 1 | Load sp_value into the core stack pointer |
| sp_value | output | XLEN | New stack pointer |
| busy | output | 1 | A sequence is in progress or reset is held |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench builds the block with a 4-bit vector number, so all 16 table slots can be taken by interrupts. It keeps the 32-bit data path and table base 0. The bench's memory answers after 0 to 3 wait cycles. Every vector runs at both the shortest and the longest latency, and the reset sequence runs at every latency. This covers both entry paths under every handshake timing. Expected table words, stack addresses and final stack pointers are derived arithmetically from the slot index and the captured stack pointer. Aborts by reset, a reset that coincides with an interrupt, and requests made while busy are run as separate scenarios.

// File: rtl/exc_entry_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes: one state per bus access, plus one state that holds the sequencer
// while the core reset request is high.
package exc_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RST_HOLD  = 3'd1,
        ST_RST_PC    = 3'd2,
        ST_RST_SP    = 3'd3,
        ST_PUSH_SR   = 3'd4,
        ST_PUSH_PC   = 3'd5,
        ST_FETCH_VEC = 3'd6
    } seq_state_e;

    // True for the states that drive a bus access.
    function automatic logic is_access(seq_state_e s);
        return (s == ST_RST_PC) || (s == ST_RST_SP) || (s == ST_PUSH_SR) ||
               (s == ST_PUSH_PC) || (s == ST_FETCH_VEC);
    endfunction

    // True for the states that write context to the stack.
    function automatic logic is_push(seq_state_e s);
        return (s == ST_PUSH_SR) || (s == ST_PUSH_PC);
    endfunction

    // True for the last access of either sequence.
    function automatic logic is_last(seq_state_e s);
        return (s == ST_RST_SP) || (s == ST_FETCH_VEC);
    endfunction

endpackage

// File: rtl/exc_seq_fsm.sv
// Sequencing state machine.
// Holds the block while the reset request is high, then walks through the
// reset reads, or the two pushes and the vector fetch. It advances a step
// only when the memory reports ready.
// Assumes: the reset request overrides every state, and interrupt requests
// are accepted only in the idle state.
module exc_seq_fsm
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       irq_req,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       accept,
    output logic       step,
    output logic       finish
);

    seq_state_e state_nx;

    // Strobes derived from the current state and the handshake.
    always_comb begin
        accept = (state == ST_IDLE) && irq_req && !rst_req;
        step   = is_access(state) && mem_ready && !rst_req;
        finish = step && is_last(state);
    end

    // Next-state selection; the reset request wins over everything.
    always_comb begin
        state_nx = state;
        if (rst_req) begin
            state_nx = ST_RST_HOLD;
        end else begin
            unique case (state)
                ST_IDLE:      if (accept) state_nx = ST_PUSH_SR;
                ST_RST_HOLD:  state_nx = ST_RST_PC;
                ST_RST_PC:    if (step) state_nx = ST_RST_SP;
                ST_RST_SP:    if (step) state_nx = ST_IDLE;
                ST_PUSH_SR:   if (step) state_nx = ST_PUSH_PC;
                ST_PUSH_PC:   if (step) state_nx = ST_FETCH_VEC;
                ST_FETCH_VEC: if (step) state_nx = ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/exc_ctx_regs.sv
// Context capture for an interrupt entry.
// Latches the core's program counter, status word, stack pointer and the
// vector number when a request is accepted. It then steps the working stack
// pointer down by one word after each completed push.
// Assumes: the incoming stack pointer is word aligned.
module exc_ctx_regs #(
    parameter int XLEN       = 32,
    parameter int VEC_W      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             push_step,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sr,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [VEC_W-1:0] irq_vec,
    output logic [XLEN-1:0]  pc_hold,
    output logic [XLEN-1:0]  sr_hold,
    output logic [XLEN-1:0]  sp_work,
    output logic [VEC_W-1:0] vec_hold
);

    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    // Capture the saved context once, at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_hold  <= '0;
            sr_hold  <= '0;
            vec_hold <= '0;
        end else if (accept) begin
            pc_hold  <= cur_pc;
            sr_hold  <= cur_sr;
            vec_hold <= irq_vec;
        end
    end

    // Working stack pointer: loaded at acceptance, decremented per push.
    always_ff @(posedge clk) begin
        if (!rst_n)         sp_work <= '0;
        else if (accept)    sp_work <= cur_sp;
        else if (push_step) sp_work <= sp_work - STEP;
    end

endmodule

// File: rtl/exc_bus_drive.sv
// Bus request generation.
// Maps the sequencer state and the captured context to the request, the
// direction, the address and the write data of the current access.
// Assumes: the table has one word per entry starting at VT_BASE, and a push
// stores at one word below the working stack pointer.
module exc_bus_drive
    import exc_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              VEC_W      = 8,
    parameter int              WORD_BYTES = 4,
    parameter logic [XLEN-1:0] VT_BASE    = '0
) (
    input  seq_state_e       state,
    input  logic [XLEN-1:0]  pc_hold,
    input  logic [XLEN-1:0]  sr_hold,
    input  logic [XLEN-1:0]  sp_work,
    input  logic [VEC_W-1:0] vec_hold,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata
);

    localparam int              WB_SHIFT = $clog2(WORD_BYTES);
    localparam logic [XLEN-1:0] STEP     = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] vec_off;

    // Byte offset of the selected table slot.
    always_comb vec_off = XLEN'(vec_hold) << WB_SHIFT;

    // Access attributes per state.
    always_comb begin
        mem_req   = is_access(state);
        mem_we    = is_push(state);
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_RST_PC:    mem_addr = VT_BASE;
            ST_RST_SP:    mem_addr = VT_BASE + STEP;
            ST_PUSH_SR: begin
                mem_addr  = sp_work - STEP;
                mem_wdata = sr_hold;
            end
            ST_PUSH_PC: begin
                mem_addr  = sp_work - STEP;
                mem_wdata = pc_hold;
            end
            ST_FETCH_VEC: mem_addr = VT_BASE + vec_off;
            default:      mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/exc_load_out.sv
// Result registers.
// Keeps the start address read during a reset sequence. At the final access
// it presents the new program counter and stack pointer, with single-cycle
// load and done strobes.
// Assumes: finish is high only on the completing cycle of the last access.
module exc_load_out
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_e      state,
    input  logic            step,
    input  logic            finish,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic [XLEN-1:0] sp_work,
    output logic            pc_load,
    output logic            sp_load,
    output logic            done,
    output logic [XLEN-1:0] pc_value,
    output logic [XLEN-1:0] sp_value
);

    logic [XLEN-1:0] pc_stage;

    // Hold the start address until the stack pointer word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pc_stage <= '0;
        else if (step && (state == ST_RST_PC))  pc_stage <= mem_rdata;
    end

    // Present the results at the end of either sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_value <= '0;
            sp_value <= '0;
        end else if (finish) begin
            if (state == ST_RST_SP) begin
                pc_value <= pc_stage;
                sp_value <= mem_rdata;
            end else begin
                pc_value <= mem_rdata;
                sp_value <= sp_work;
            end
        end
    end

    // Single-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load <= 1'b0;
            sp_load <= 1'b0;
            done    <= 1'b0;
        end else begin
            pc_load <= finish;
            sp_load <= finish;
            done    <= finish;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer, top level.
// Carries the core from a reset request or an accepted interrupt into program
// execution. On reset it reads the start address and the stack pointer from
// the vector table. On an interrupt it pushes the status word and the program
// counter, then reads the handler address.
// Assumes: the memory holds each access until it answers with ready, and an
// external arbiter has already picked the interrupt and its vector.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              VEC_W      = 8,
    parameter int              WORD_BYTES = 4,
    parameter logic [XLEN-1:0] VT_BASE    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sr,
    input  logic [XLEN-1:0]  cur_sp,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic             pc_load,
    output logic [XLEN-1:0]  pc_value,
    output logic             sp_load,
    output logic [XLEN-1:0]  sp_value,
    output logic             busy,
    output logic             done
);

    seq_state_e       state;
    logic             accept;
    logic             step;
    logic             finish;
    logic             push_step;
    logic [XLEN-1:0]  pc_hold;
    logic [XLEN-1:0]  sr_hold;
    logic [XLEN-1:0]  sp_work;
    logic [VEC_W-1:0] vec_hold;

    // Busy whenever the sequencer is not idle, including reset hold.
    always_comb busy = (state != ST_IDLE);

    // A completed push moves the working stack pointer.
    always_comb push_step = step && is_push(state);

    exc_seq_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .irq_req   (irq_req),
        .mem_ready (mem_ready),
        .state     (state),
        .accept    (accept),
        .step      (step),
        .finish    (finish)
    );

    exc_ctx_regs #(
        .XLEN       (XLEN),
        .VEC_W      (VEC_W),
        .WORD_BYTES (WORD_BYTES)
    ) ctx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .push_step (push_step),
        .cur_pc    (cur_pc),
        .cur_sr    (cur_sr),
        .cur_sp    (cur_sp),
        .irq_vec   (irq_vec),
        .pc_hold   (pc_hold),
        .sr_hold   (sr_hold),
        .sp_work   (sp_work),
        .vec_hold  (vec_hold)
    );

    exc_bus_drive #(
        .XLEN       (XLEN),
        .VEC_W      (VEC_W),
        .WORD_BYTES (WORD_BYTES),
        .VT_BASE    (VT_BASE)
    ) bus_i (
        .state     (state),
        .pc_hold   (pc_hold),
        .sr_hold   (sr_hold),
        .sp_work   (sp_work),
        .vec_hold  (vec_hold),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    exc_load_out #(
        .XLEN (XLEN)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .step      (step),
        .finish    (finish),
        .mem_rdata (mem_rdata),
        .sp_work   (sp_work),
        .pc_load   (pc_load),
        .sp_load   (sp_load),
        .done      (done),
        .pc_value  (pc_value),
        .sp_value  (sp_value)
    );

endmodule

// File: rtl/exc_entry_seq_chk.sv
// Port-level protocol checks for the exception entry sequencer, bound to every
// instance of the top module.
module exc_entry_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            busy,
    input logic            done,
    input logic            pc_load
);

    // While reset is requested, the block is busy and off the bus.
    assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (busy && !mem_req));

    // Bus traffic only happens inside a sequence.
    assert_req_in_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // A pending access keeps all its attributes until ready.
    assert_access_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !rst_req) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // A reset request never lets a sequence finish in the next cycle.
    assert_reset_blocks_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !done);

    // Done is a one-cycle pulse, and the block is idle while it is high.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // The program counter load is a one-cycle pulse.
    assert_pc_load_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .pc_load   (pc_load)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    localparam int XLEN  = 32;
    localparam int VEC_W = 4;
    localparam int NVEC  = 1 << VEC_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rst_req = 1'b0;
    logic             irq_req = 1'b0;
    logic [VEC_W-1:0] irq_vec = '0;
    logic [XLEN-1:0]  cur_pc = '0;
    logic [XLEN-1:0]  cur_sr = '0;
    logic [XLEN-1:0]  cur_sp = '0;
    logic             mem_req;
    logic             mem_we;
    logic [XLEN-1:0]  mem_addr;
    logic [XLEN-1:0]  mem_wdata;
    logic [XLEN-1:0]  mem_rdata = '0;
    logic             mem_ready = 1'b0;
    logic             pc_load;
    logic [XLEN-1:0]  pc_value;
    logic             sp_load;
    logic [XLEN-1:0]  sp_value;
    logic             busy;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    int wr_n     = 0;
    int rd_n     = 0;
    int done_n   = 0;
    int stab_err = 0;
    logic [XLEN-1:0] wr_addr [0:7];
    logic [XLEN-1:0] wr_data [0:7];
    logic [XLEN-1:0] rd_addr [0:7];

    exc_entry_seq #(.XLEN(XLEN), .VEC_W(VEC_W), .WORD_BYTES(4), .VT_BASE('0)) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_req(irq_req),
        .irq_vec(irq_vec), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc_load(pc_load), .pc_value(pc_value), .sp_load(sp_load),
        .sp_value(sp_value), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    // Table word held in slot i.
    function automatic logic [XLEN-1:0] vt_word(int i);
        return 32'h0C00_0010 + 32'(i) * 32'h0000_0104;
    endfunction

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Memory responder: answers after lat idle cycles and logs each access.
    initial begin
        int cnt = 0;
        logic [XLEN-1:0] h_a = '0;
        logic [XLEN-1:0] h_d = '0;
        logic h_w = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ready = 1'b0;
                cnt = 0;
            end else if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt > 0 && (mem_addr !== h_a || mem_we !== h_w || mem_wdata !== h_d))
                    stab_err++;
                h_a = mem_addr; h_w = mem_we; h_d = mem_wdata;
                if (cnt >= lat) begin
                    mem_ready = 1'b1;
                    mem_rdata = (mem_addr < 64) ? vt_word(int'(mem_addr >> 2)) : 32'hBAD0_BAD0;
                    if (mem_we) begin
                        if (wr_n < 8) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
                        wr_n++;
                    end else begin
                        if (rd_n < 8) rd_addr[rd_n] = mem_addr;
                        rd_n++;
                    end
                end else begin
                    cnt++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Done pulse counter.
    initial forever begin
        @(negedge clk);
        if (done) done_n++;
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    task automatic clear_logs();
        wr_n = 0;
        rd_n = 0;
    endtask

    // Wait for done at a negedge, check strobes and that done lasts one cycle.
    task automatic wait_done(string req);
        bit seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        check({req, " done seen"}, 32'(seen), 32'd1);
        check({req, " pc_load"}, 32'(pc_load), 32'd1);
        check({req, " sp_load"}, 32'(sp_load), 32'd1);
        check("R10 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        check("R10 done single cycle", 32'(done), 32'd0);
        check("R10 pc_load single cycle", 32'(pc_load), 32'd0);
    endtask

    task automatic run_reset(int l);
        lat = l;
        clear_logs();
        rst_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 busy in hold", 32'(busy), 32'd1);
        check("R2 no access in hold", 32'(mem_req), 32'd0);
        rst_req = 1'b0;
        wait_done("R3");
        check("R2 read count", 32'(rd_n), 32'd2);
        check("R2 write count", 32'(wr_n), 32'd0);
        check("R2 first read addr", rd_addr[0], 32'd0);
        check("R2 second read addr", rd_addr[1], 32'd4);
        check("R3 pc_value", pc_value, vt_word(0));
        check("R3 sp_value", sp_value, vt_word(1));
    endtask

    task automatic run_irq(int l, int v, logic [XLEN-1:0] pc, logic [XLEN-1:0] sr,
                           logic [XLEN-1:0] sp);
        lat = l;
        clear_logs();
        cur_pc = pc; cur_sr = sr; cur_sp = sp;
        irq_vec = VEC_W'(v);
        irq_req = 1'b1;
        @(negedge clk);
        check("R4 busy after accept", 32'(busy), 32'd1);
        irq_req = 1'b0;
        cur_pc = ~pc; cur_sr = ~sr; cur_sp = sp + 32'h100;
        irq_vec = VEC_W'(v + 3);
        wait_done("R6");
        check("R5 write count", 32'(wr_n), 32'd2);
        check("R5 sr addr", wr_addr[0], sp - 32'd4);
        check("R5 sr data", wr_data[0], sr);
        check("R5 pc addr", wr_addr[1], sp - 32'd8);
        check("R5 pc data", wr_data[1], pc);
        check("R6 read count", 32'(rd_n), 32'd1);
        check("R6 vector addr", rd_addr[0], 32'(v) * 32'd4);
        check("R6 pc_value", pc_value, vt_word(v));
        check("R6 sp_value", sp_value, sp - 32'd8);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 pc_load", 32'(pc_load), 32'd0);
        check("R1 sp_load", 32'(sp_load), 32'd0);

        for (int l = 0; l < 4; l++) run_reset(l);

        for (int l = 0; l < 4; l += 3)
            for (int v = 0; v < NVEC; v++)
                run_irq(l, v, 32'h0000_4000 + 32'(v) * 32'd6, 32'h0000_00F0 ^ 32'(v),
                        32'h0000_8000 - 32'(v) * 32'd16);

        // R8: reset aborts an interrupt after its first push.
        lat = 2;
        clear_logs();
        cur_pc = 32'h1234_5670; cur_sr = 32'h0000_0033; cur_sp = 32'h0000_9000;
        irq_vec = 4'd7;
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk);
            if (wr_n >= 1) break;
        end
        @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_req = 1'b0;
        wait_done("R8");
        check("R8 writes after abort", 32'(wr_n), 32'd1);
        check("R8 pc after abort", pc_value, vt_word(0));
        check("R8 sp after abort", sp_value, vt_word(1));

        // R8: reset and interrupt in the same cycle.
        lat = 1;
        clear_logs();
        rst_req = 1'b1;
        irq_req = 1'b1;
        irq_vec = 4'd9;
        @(negedge clk);
        @(negedge clk);
        rst_req = 1'b0;
        irq_req = 1'b0;
        wait_done("R8");
        check("R8 same-cycle writes", 32'(wr_n), 32'd0);
        check("R8 same-cycle pc", pc_value, vt_word(0));

        // R9: a request held only while busy is ignored.
        lat = 3;
        clear_logs();
        d0 = done_n;
        cur_pc = 32'h0000_2220; cur_sr = 32'h0000_0005; cur_sp = 32'h0000_7000;
        irq_vec = 4'd5;
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        @(negedge clk);
        irq_vec = 4'd9;
        irq_req = 1'b1;
        repeat (3) @(negedge clk);
        irq_req = 1'b0;
        wait_done("R9");
        repeat (20) @(negedge clk);
        check("R9 pc from first vector", pc_value, vt_word(5));
        check("R9 single sequence writes", 32'(wr_n), 32'd2);
        check("R9 single done", 32'(done_n - d0), 32'd1);
        check("R9 idle after", 32'(busy), 32'd0);

        check("R7 access steady until ready", 32'(stab_err), 32'd0);
        report();
    end

endmodule